// File: doc/BRIEF.md
# SPI Register Access Master

This block drives a four-wire SPI bus to read and write a small bank of 12-bit registers held in an external data converter. On the user side it takes one request at a time through a valid/ready handshake. Each request carries a direction flag, a 3-bit register address and 12 bits of write data. Completion is reported by a one-cycle done pulse, with the read value alongside. An address outside the implemented range is refused with a one-cycle error pulse.

Every bus frame is 16 bits long and shifted most significant bit first in SPI mode 0. A write needs one frame. A read needs two frames:

- The first frame carries the command.
- Chip select then returns high for a guard interval.
- The second frame clocks the reply in from the converter.

The SCLK rate and the guard interval are given as a frequency and a time in parameters. They are converted into system-clock counts, each rounded up so the minimum is always met.

Top module: `spiRegMaster`

## Requirements
- R1: A command frame carries the direction flag in bit 15 (1 = write, 0 = read), the register address in bits 14:12 and the data field in bits 11:0. It is shifted out MSB first on spiMosi.
- R2: An accepted write to a valid address produces exactly one frame whose data field is reqWdata. It is followed by a one-cycle rspDone pulse after chip select has returned high. rspErr stays low.
- R3: An accepted read produces exactly two frames. The first has a zero data field. During the second, spiMosi is held at 0. rspRdata then equals bits 11:0 of the 16 bits received on spiMiso in the second frame, and this value is valid in the same cycle as the rspDone pulse.
- R4: Between the two frames of a read, spiCsN stays high for at least GUARD_NS of time, rounded up to whole clocks (1 cycle at the default 100 MHz and 10 ns).
- R5: SCLK is high for exactly HALF_DIV clocks and low for exactly HALF_DIV clocks between edges. HALF_DIV is the SCLK_MAX_HZ limit rounded up: 5 clocks at the defaults. Each frame contains exactly 16 rising SCLK edges, and SCLK is low whenever spiCsN is high.
- R6: SPI mode 0 is used. spiMosi changes only while SCLK is low, and spiMiso is sampled on the rising SCLK edge.
- R7: A request for an address above 5 (valid addresses are 0 to 5) gives a single-cycle rspErr pulse in the cycle after acceptance. It causes no chip-select activity and no rspDone.
- R8: reqReady is low from acceptance of a valid request until its rspDone. Requests presented during that time are ignored and cause no additional frame.
- R9: After reset: spiCsN is high, SCLK is low, reqReady is high, and rspDone and rspErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 3 | Register address |
| reqWdata | input | 12 | Write value |
| rspDone | output | 1 | One-cycle pulse when an access has finished |
| rspErr | output | 1 | One-cycle pulse when a request was refused |
| rspRdata | output | 12 | Value returned by the last read |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the converter |
| spiMiso | input | 1 | Serial data from the converter |

## Verification
A sequencer stuck in the wrong state shows up at once as a missing or extra chip-select frame, or as a frame with other than 16 SCLK rises. This is visible within one frame time, about 170 clocks. A divider or bit-counter fault shows up as a wrong SCLK high or low width at the very next edge. A corrupted receive or transmit shift register shows up as a wrong captured command word or a wrong rspRdata when the access completes. The cases covered are:

- boundary addresses 0, 5, 6 and 7;
- data words of all zeros and all ones;
- a request held active during a busy transfer.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } ctrlState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadCmd;
    logic loadZero;
    logic divRestart;
    logic rise;
    logic fall;
    logic latchRd;
    logic gapStart;
  } dpStrobe_t;

  // clocks per SCLK half period, rounded up so SCLK never exceeds sclkHz
  function automatic int calcHalfDiv(longint clkHz, longint sclkHz);
    longint q;
    q = (clkHz + 2 * sclkHz - 1) / (2 * sclkHz);
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  // clocks covering guardNs, rounded up, at least one
  function automatic int calcGuard(longint clkHz, longint guardNs);
    longint q;
    q = (guardNs * clkHz + 64'd999_999_999) / 64'd1_000_000_000;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int DATA_W     = 12,
  parameter int HALF_DIV   = 5,
  parameter int GUARD_CYC  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [FRAME_BITS-1:0] frameIn,
  input  logic                  spiMiso,
  output logic                  spiMosi,
  output logic                  sclkLvl,
  output logic                  tick,
  output logic                  lastBit,
  output logic                  gapDone,
  output logic [DATA_W-1:0]     rdData
);

  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int GAP_W = $clog2(GUARD_CYC + 1);

  logic [DIV_W-1:0]      divCnt;
  logic [BIT_W-1:0]      bitCnt;
  logic [GAP_W-1:0]      gapCnt;
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     rxShift;
  logic                  sclkQ;

  // half-period timer
  assign tick = (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.divRestart || tick) begin
      divCnt <= DIV_W'(HALF_DIV - 1);
    end else begin
      divCnt <= divCnt - 1'b1;
    end
  end

  // serial clock level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
    end else if (strb.rise) begin
      sclkQ <= 1'b1;
    end else if (strb.fall) begin
      sclkQ <= 1'b0;
    end
  end

  // transmit register: MSB drives the line, advances on the falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.loadCmd) begin
      txShift <= frameIn;
    end else if (strb.loadZero) begin
      txShift <= '0;
    end else if (strb.fall) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  // receive register keeps only the low data bits of the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.rise) begin
      rxShift <= {rxShift[DATA_W-2:0], spiMiso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.loadCmd || strb.loadZero) begin
      bitCnt <= '0;
    end else if (strb.rise) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // chip-select guard timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strb.gapStart) begin
      gapCnt <= GAP_W'(GUARD_CYC - 1);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.latchRd) begin
      rdData <= rxShift;
    end
  end

  assign lastBit = (bitCnt == BIT_W'(FRAME_BITS));
  assign gapDone = (gapCnt == '0);
  assign spiMosi = txShift[FRAME_BITS-1];
  assign sclkLvl = sclkQ;

endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 12,
  parameter int MAX_ADDR = 5,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic                  sclkLvl,
  input  logic                  tick,
  input  logic                  lastBit,
  input  logic                  gapDone,
  output logic                  reqReady,
  output logic                  rspDone,
  output logic                  rspErr,
  output logic                  spiCsN,
  output logic [FRAME_BITS-1:0] frameOut,
  output dpStrobe_t             strb
);

  ctrlState_t state, stateNext;
  logic csQ, csNext;
  logic isRead, isReadNext;
  logic second, secondNext;
  logic doneQ, doneNext;
  logic errQ, errNext;

  // command word: flag, address, data (zero for reads)
  assign frameOut = {reqWrite, reqAddr, reqWrite ? reqWdata : {DATA_W{1'b0}}};

  always_comb begin
    stateNext  = state;
    csNext     = csQ;
    isReadNext = isRead;
    secondNext = second;
    doneNext   = 1'b0;
    errNext    = 1'b0;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (int'(reqAddr) > MAX_ADDR) begin
            errNext = 1'b1;
          end else begin
            strb.loadCmd    = 1'b1;
            strb.divRestart = 1'b1;
            csNext          = 1'b0;
            isReadNext      = !reqWrite;
            secondNext      = 1'b0;
            stateNext       = ST_SHIFT;
          end
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sclkLvl) begin
            strb.rise = 1'b1;
          end else begin
            strb.fall = 1'b1;
            if (lastBit) stateNext = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          csNext = 1'b1;
          if (isRead && !second) begin
            strb.gapStart = 1'b1;
            stateNext     = ST_GAP;
          end else begin
            strb.latchRd = isRead;
            doneNext     = 1'b1;
            stateNext    = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (gapDone) begin
          strb.loadZero   = 1'b1;
          strb.divRestart = 1'b1;
          csNext          = 1'b0;
          secondNext      = 1'b1;
          stateNext       = ST_SHIFT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      csQ    <= 1'b1;
      isRead <= 1'b0;
      second <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      state  <= stateNext;
      csQ    <= csNext;
      isRead <= isReadNext;
      second <= secondNext;
      doneQ  <= doneNext;
      errQ   <= errNext;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspDone  = doneQ;
  assign rspErr   = errQ;
  assign spiCsN   = csQ;

endmodule

// File: rtl/spiRegMaster.sv
module spiRegMaster
  import spiRegPkg::*;
#(
  parameter longint CLK_HZ      = 100_000_000,
  parameter longint SCLK_MAX_HZ = 10_000_000,
  parameter longint GUARD_NS    = 10,
  parameter int     ADDR_W      = 3,
  parameter int     DATA_W      = 12,
  parameter int     MAX_ADDR    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);

  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int HALF_DIV   = calcHalfDiv(CLK_HZ, SCLK_MAX_HZ);
  localparam int GUARD_CYC  = calcGuard(CLK_HZ, GUARD_NS);

  dpStrobe_t             strb;
  logic [FRAME_BITS-1:0] frameWord;
  logic                  sclkLvl;
  logic                  tick;
  logic                  lastBit;
  logic                  gapDone;

  spiRegCtrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MAX_ADDR(MAX_ADDR)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .sclkLvl (sclkLvl),
    .tick    (tick),
    .lastBit (lastBit),
    .gapDone (gapDone),
    .reqReady(reqReady),
    .rspDone (rspDone),
    .rspErr  (rspErr),
    .spiCsN  (spiCsN),
    .frameOut(frameWord),
    .strb    (strb)
  );

  spiRegDatapath #(
    .FRAME_BITS(FRAME_BITS),
    .DATA_W    (DATA_W),
    .HALF_DIV  (HALF_DIV),
    .GUARD_CYC (GUARD_CYC)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .frameIn(frameWord),
    .spiMiso(spiMiso),
    .spiMosi(spiMosi),
    .sclkLvl(sclkLvl),
    .tick   (tick),
    .lastBit(lastBit),
    .gapDone(gapDone),
    .rdData (rspRdata)
  );

  assign spiSclk = sclkLvl;

endmodule

// File: rtl/spiRegChecker.sv
module spiRegChecker
  import spiRegPkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter longint GUARD_NS   = 10,
  parameter int     ADDR_W     = 3,
  parameter int     MAX_ADDR   = 5,
  parameter int     FRAME_BITS = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspDone,
  input logic              rspErr,
  input logic              spiCsN,
  input logic              spiSclk,
  input logic              spiMosi
);

  localparam int GUARD = calcGuard(CLK_HZ, GUARD_NS);

  logic [15:0] csHighRun;
  logic [7:0]  riseCnt;
  logic        sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighRun <= '1;
      riseCnt   <= '0;
      sclkQ     <= 1'b0;
    end else begin
      sclkQ <= spiSclk;
      if (spiCsN) begin
        if (csHighRun != '1) csHighRun <= csHighRun + 1'b1;
        riseCnt <= '0;
      end else begin
        csHighRun <= '0;
        if (spiSclk && !sclkQ) riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  // R4: guard between frames
  p_cs_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (csHighRun >= 16'(GUARD)));

  // R5: sixteen SCLK rises per frame
  p_frame_rises_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> (riseCnt == 8'(FRAME_BITS)));

  // R5: SCLK idles low outside a frame
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  // R6: MOSI moves only while SCLK is low
  p_mosi_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && $past(!spiCsN) && !$stable(spiMosi)) |-> !spiSclk);

  // R7: bad address refused without bus activity
  p_bad_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (int'(reqAddr) > MAX_ADDR)) |=> (rspErr && spiCsN));

  // R8: not ready while a frame is on the bus
  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> !reqReady);

  // R2: completion and refusal never coincide
  p_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(rspDone && rspErr));

  // R3: done only after chip select is released
  p_done_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> spiCsN);

endmodule

bind spiRegMaster spiRegChecker #(
  .CLK_HZ    (CLK_HZ),
  .GUARD_NS  (GUARD_NS),
  .ADDR_W    (ADDR_W),
  .MAX_ADDR  (MAX_ADDR),
  .FRAME_BITS(1 + ADDR_W + DATA_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqAddr (reqAddr),
  .rspDone (rspDone),
  .rspErr  (rspErr),
  .spiCsN  (spiCsN),
  .spiSclk (spiSclk),
  .spiMosi (spiMosi)
);

// File: tb/spiRegMaster_test.sv
`timescale 1ns/1ps
module spiRegMaster_test;

  localparam int EXP_HALF  = 5;
  localparam int EXP_GUARD = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [11:0] reqWdata = '0;
  logic        reqReady, rspDone, rspErr, spiCsN, spiSclk, spiMosi, spiMiso;
  logic [11:0] rspRdata;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  spiRegMaster uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // ---- slave model / bus monitor, sampled on the falling clk edge ----
  int          framesSeen = 0;
  int          replyBase = 0;
  logic [15:0] replyWord = '0;
  logic [15:0] misoShift = '0;
  logic [15:0] capFrame [64];
  int          bitsRec [64];
  int          gapRec [64];
  int          csHighRun = 100;
  int          hiRun = 0, loRun = 0;
  int          hiMin = 1000, hiMax = 0, loMin = 1000, loMax = 0;
  int          mosiViol = 0, idleViol = 0;
  logic        prevCs = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0;

  assign spiMiso = misoShift[15];

  always @(negedge clk) begin
    if (prevCs && !spiCsN) begin
      misoShift = ((framesSeen - replyBase) == 1) ? replyWord : ~replyWord;
      gapRec[framesSeen % 64]   = csHighRun;
      capFrame[framesSeen % 64] = '0;
      bitsRec[framesSeen % 64]  = 0;
      framesSeen++;
      loRun = 0;
    end
    if (spiCsN) csHighRun++; else csHighRun = 0;
    if (spiCsN && spiSclk) idleViol++;
    if (!spiCsN && !prevCs && spiSclk && prevSclk && (spiMosi != prevMosi)) mosiViol++;
    if (!spiCsN && spiSclk && !prevSclk) begin
      capFrame[(framesSeen - 1) % 64] = {capFrame[(framesSeen - 1) % 64][14:0], spiMosi};
      bitsRec[(framesSeen - 1) % 64]++;
      if (loRun < loMin) loMin = loRun;
      if (loRun > loMax) loMax = loRun;
      hiRun = 1;
    end else if (!spiSclk && prevSclk) begin
      if (hiRun < hiMin) hiMin = hiRun;
      if (hiRun > hiMax) hiMax = hiRun;
      misoShift = {misoShift[14:0], 1'b0};
      loRun = 1;
    end else if (spiSclk) begin
      hiRun++;
    end else if (!spiCsN) begin
      loRun++;
    end
    prevCs = spiCsN;
    prevSclk = spiSclk;
    prevMosi = spiMosi;
  end

  // ---- helpers ----
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic w, input logic [2:0] a, input logic [11:0] d,
                          output logic gotDone, output logic gotErr, output logic [11:0] rd);
    int n;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = w; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspDone && !rspErr && n < 5000) begin
      @(negedge clk);
      n++;
    end
    gotDone = rspDone; gotErr = rspErr; rd = rspRdata;
  endtask

  // ---- scenarios ----
  task automatic tReset();
    @(negedge clk);
    chk(spiCsN == 1'b1, "R9", "csN after reset", spiCsN, 1);
    chk(spiSclk == 1'b0, "R9", "sclk after reset", spiSclk, 0);
    chk(reqReady == 1'b1, "R9", "ready after reset", reqReady, 1);
    chk(rspDone == 1'b0, "R9", "done after reset", rspDone, 0);
    chk(rspErr == 1'b0, "R9", "err after reset", rspErr, 0);
  endtask

  task automatic tWrite(input logic [2:0] a, input logic [11:0] d);
    int base; logic dn, er; logic [11:0] rd;
    int v0;
    v0 = mosiViol + idleViol;
    base = framesSeen; replyBase = framesSeen; replyWord = 16'h0F0F;
    doAccess(1'b1, a, d, dn, er, rd);
    chk(dn == 1'b1, "R2", "write done", dn, 1);
    chk(er == 1'b0, "R2", "write err", er, 0);
    chk(framesSeen - base == 1, "R2", "write frame count", framesSeen - base, 1);
    chk(capFrame[base % 64] == {1'b1, a, d}, "R1", "write frame word",
        capFrame[base % 64], {1'b1, a, d});
    chk(bitsRec[base % 64] == 16, "R5", "write rises", bitsRec[base % 64], 16);
    chk(mosiViol + idleViol == v0, "R6", "mosi/sclk rule breaks", mosiViol + idleViol, v0);
    @(negedge clk);
    chk(rspDone == 1'b0, "R2", "done is a pulse", rspDone, 0);
  endtask

  task automatic tRead(input logic [2:0] a, input logic [15:0] reply);
    int base; logic dn, er; logic [11:0] rd;
    base = framesSeen; replyBase = framesSeen; replyWord = reply;
    doAccess(1'b0, a, 12'hABC, dn, er, rd);
    chk(dn == 1'b1, "R3", "read done", dn, 1);
    chk(framesSeen - base == 2, "R3", "read frame count", framesSeen - base, 2);
    chk(capFrame[base % 64] == {1'b0, a, 12'h000}, "R1", "read command word",
        capFrame[base % 64], {1'b0, a, 12'h000});
    chk(capFrame[(base + 1) % 64] == 16'h0000, "R3", "second frame mosi",
        capFrame[(base + 1) % 64], 0);
    chk(bitsRec[(base + 1) % 64] == 16, "R5", "second frame rises", bitsRec[(base + 1) % 64], 16);
    chk(rd == reply[11:0], "R3", "read data", rd, reply[11:0]);
    chk(gapRec[(base + 1) % 64] >= EXP_GUARD, "R4", "cs high gap",
        gapRec[(base + 1) % 64], EXP_GUARD);
  endtask

  task automatic tBad(input logic [2:0] a);
    int base; logic dn, er; logic [11:0] rd;
    base = framesSeen;
    doAccess(1'b1, a, 12'h123, dn, er, rd);
    chk(er == 1'b1, "R7", "error pulse", er, 1);
    chk(dn == 1'b0, "R7", "no done on error", dn, 0);
    @(negedge clk);
    chk(rspErr == 1'b0, "R7", "error is one cycle", rspErr, 0);
    chk(reqReady == 1'b1, "R7", "ready after error", reqReady, 1);
    repeat (20) @(negedge clk);
    chk(framesSeen == base, "R7", "no frame on bad address", framesSeen - base, 0);
  endtask

  task automatic tBusy();
    int base; int n; int readyHigh;
    base = framesSeen; replyBase = framesSeen;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = 1'b1; reqAddr = 3'd2; reqWdata = 12'h5A5; reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 3'd4; reqWdata = 12'h3C3;   // held active while busy
    n = 0; readyHigh = 0;
    while (!rspDone && n < 5000) begin
      if (reqReady) readyHigh++;
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    chk(readyHigh == 0, "R8", "ready low while busy", readyHigh, 0);
    repeat (40) @(negedge clk);
    chk(framesSeen - base == 1, "R8", "ignored request frames", framesSeen - base, 1);
    chk(capFrame[base % 64] == {1'b1, 3'd2, 12'h5A5}, "R8", "original frame kept",
        capFrame[base % 64], {1'b1, 3'd2, 12'h5A5});
  endtask

  task automatic tTiming();
    chk(hiMin == EXP_HALF && hiMax == EXP_HALF, "R5", "sclk high width", {hiMin[15:0], hiMax[15:0]}, EXP_HALF);
    chk(loMin == EXP_HALF && loMax == EXP_HALF, "R5", "sclk low width", {loMin[15:0], loMax[15:0]}, EXP_HALF);
    chk(idleViol == 0, "R5", "sclk high with cs high", idleViol, 0);
    chk(mosiViol == 0, "R6", "mosi change with sclk high", mosiViol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tWrite(3'd1, 12'h2A7);
    tWrite(3'd5, 12'hFFF);
    tWrite(3'd0, 12'h000);
    tRead(3'd3, 16'hA5C3);
    tRead(3'd0, 16'h0FFF);
    tRead(3'd5, 16'hF000);
    tBad(3'd6);
    tBad(3'd7);
    tBusy();
    tRead(3'd2, 16'h1801);
    tTiming();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule